// File: doc/BRIEF.md
# Atomic-Clear Interrupt Aggregator

The block gathers a parameterised number of device request lines (32 by default) into a single interrupt request for a processor. Each line passes through a two-stage synchronizer. A per-line trigger setting decides whether the line records a pending event while its input is high (level) or only on a low-to-high change (rising edge). Pending events are kept in a status register. An enable register chooses which of the pending bits can raise the combined output.

Software reaches the three registers through a small synchronous register port. Reads return data one cycle after the request. The status register is cleared by writing ones: each 1 clears its own pending bit, and each 0 leaves its bit alone. A handler can therefore clear one source, or write back a status word it read earlier, and never lose an event that arrived after that read. A new event that lands in the same cycle as a clear of the same bit wins, so the bit stays pending.

Top module: `irq_collector`

## Requirements
- R1: A write to address 1 clears every status bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R2: Writing back a status value read earlier clears only the bits that were set in it; a bit that became pending after the read stays pending.
- R3: A level line (trigger bit 0) whose input is still high is pending again straight after a clear.
- R4: A rising-edge line (trigger bit 1) latches one 0-to-1 input change into its pending bit, and the bit stays set after the input falls until software clears it.
- R5: `irq_o` is high exactly when some bit is set in both the status and the enable register; a line whose enable bit is 0 still records pending status.
- R6: Clearing one line never changes the pending state of any other line.
- R7: When a new event and a clear of the same bit fall in the same cycle, the bit stays pending.
- R8: Register map: address 0 is the enable register (read/write, bit i enables line i), address 1 is the status register (read, write-one-to-clear), address 2 is the trigger register (read/write, bit i: 0 = level, 1 = rising edge), and address 3 reads as zero. Read data appears on `rd_data` one clock after the read request.
- R9: After reset the status, enable and trigger registers are all zero and `irq_o` is low.
- R10: An input that is high before clock edge k is visible in the status bit (and in `irq_o`, if enabled) after edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_LINES | Device request lines, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | N_LINES | Write data |
| rd_data | output | N_LINES | Read data, valid one cycle after a read |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong pending bit appears at the ports in two ways. It changes `irq_o` in the same cycle if the line is enabled, and it shows in a status read one cycle after the request. A clear that is too wide, a lost edge or a wrong set/clear priority therefore shows up in the first status read after the faulty update. The bench lets the inputs settle between steps, compares each status, enable and trigger read and `irq_o` against a model built from the requirements, and checks the synchronizer delay and the same-cycle collision with directed timing.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_ENABLE  = 2'd0,
        RA_STATUS  = 2'd1,
        RA_TRIGGER = 2'd2,
        RA_UNUSED  = 2'd3
    } reg_addr_e;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_RISE  = 1'b1
    } trig_e;

    typedef struct packed {
        logic      sel;
        logic      we;
        reg_addr_e addr;
    } bus_cmd_t;

    // Event for one line given its trigger kind, synchronized sample and delayed sample
    function automatic logic line_event(trig_e kind, logic cur, logic prev);
        return (kind == TRIG_RISE) ? (cur & ~prev) : cur;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] req_i,
    output logic [N_LINES-1:0] cur_o,
    output logic [N_LINES-1:0] prev_o
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic meta_q, stab_q, dly_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
                dly_q  <= 1'b0;
            end else begin
                meta_q <= req_i[i];
                stab_q <= meta_q;
                dly_q  <= stab_q;
            end
        end
        assign cur_o[i]  = stab_q;
        assign prev_o[i] = dly_q;
    end
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] set_i,
    input  logic [N_LINES-1:0] clr_i,
    output logic [N_LINES-1:0] pend_o
);
    logic [N_LINES-1:0] pend_q;

    // a set in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= set_i | (pend_q & ~clr_i);
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_cmd_t           cmd,
    input  logic [N_LINES-1:0] wdata,
    input  logic [N_LINES-1:0] pend_i,
    output logic [N_LINES-1:0] enable_o,
    output logic [N_LINES-1:0] trig_o,
    output logic [N_LINES-1:0] rdata_o
);
    logic [N_LINES-1:0] enable_q, trig_q, rdata_q, rd_mux;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            trig_q   <= '0;
        end else if (cmd.sel && cmd.we) begin
            if (cmd.addr == RA_ENABLE)  enable_q <= wdata;
            if (cmd.addr == RA_TRIGGER) trig_q   <= wdata;
        end
    end

    always_comb begin
        unique case (cmd.addr)
            RA_ENABLE:  rd_mux = enable_q;
            RA_STATUS:  rd_mux = pend_i;
            RA_TRIGGER: rd_mux = trig_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                      rdata_q <= '0;
        else if (cmd.sel && !cmd.we)  rdata_q <= rd_mux;
    end

    assign enable_o = enable_q;
    assign trig_o   = trig_q;
    assign rdata_o  = rdata_q;
endmodule

// File: rtl/irq_collector.sv
module irq_collector
    import irqc_pkg::*;
#(
    parameter int N_LINES = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_LINES-1:0]  req_i,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [N_LINES-1:0]  bus_wdata,
    output logic [N_LINES-1:0]  rd_data,
    output logic                irq_o
);
    bus_cmd_t           cmd;
    logic [N_LINES-1:0] cur_s, prev_s;
    logic [N_LINES-1:0] set_vec, clr_vec, pend_q, mask_q, trig_q;

    assign cmd = '{sel: bus_sel, we: bus_we, addr: reg_addr_e'(bus_addr)};

    irqc_sync #(.N_LINES(N_LINES)) u_sync (
        .clk(clk), .rst(rst), .req_i(req_i), .cur_o(cur_s), .prev_o(prev_s)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_evt
        assign set_vec[i] = line_event(trig_e'(trig_q[i]), cur_s[i], prev_s[i]);
    end

    assign clr_vec = (cmd.sel && cmd.we && cmd.addr == RA_STATUS) ? bus_wdata : '0;

    irqc_pend #(.N_LINES(N_LINES)) u_pend (
        .clk(clk), .rst(rst), .set_i(set_vec), .clr_i(clr_vec), .pend_o(pend_q)
    );

    irqc_regs #(.N_LINES(N_LINES)) u_regs (
        .clk(clk), .rst(rst), .cmd(cmd), .wdata(bus_wdata), .pend_i(pend_q),
        .enable_o(mask_q), .trig_o(trig_q), .rdata_o(rd_data)
    );

    assign irq_o = |(pend_q & mask_q);
endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk #(
    parameter int N_LINES = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [N_LINES-1:0] pend,
    input logic [N_LINES-1:0] set_vec,
    input logic [N_LINES-1:0] clr_vec,
    input logic [N_LINES-1:0] mask,
    input logic               irq_o
);
    // R1 / R6: a bit written 1 with no competing event is clear next cycle
    assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
        (clr_vec != '0) |=> ((pend & $past(clr_vec & ~set_vec)) == '0));

    // R6: a pending bit only drops when its own clear bit was written
    assert_no_stray_drop_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend) & ~pend & ~$past(clr_vec)) == '0));

    // R7: an event always leaves its bit pending, clear or not
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(set_vec) & ~pend) == '0));

    // R5: nothing enabled means no request
    assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq_o);

    // R5: no pending bit means no request
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> !irq_o);
endmodule

bind irq_collector irq_collector_chk #(.N_LINES(N_LINES)) u_chk (
    .clk(clk), .rst(rst), .pend(pend_q), .set_vec(set_vec),
    .clr_vec(clr_vec), .mask(mask_q), .irq_o(irq_o)
);

// File: tb/irq_collector_bench.sv
module irq_collector_bench;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req_i = '0;
    logic          bus_sel = 1'b0, bus_we = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  rd_data;
    logic          irq_o;

    int checks = 0, errors = 0;
    logic [N-1:0] m_pend, m_mask, m_trig, m_req;

    always #10 clk = ~clk;   // 50 MHz

    irq_collector #(.N_LINES(N)) u_irq_collector (
        .clk(clk), .rst(rst), .req_i(req_i), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic check(string req, logic [N-1:0] got, logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [N-1:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [1:0] a, output logic [N-1:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // Model functions from the requirements (settled behaviour)
    function automatic logic [N-1:0] f_after_req(logic [N-1:0] p, logic [N-1:0] oldr,
                                                 logic [N-1:0] newr, logic [N-1:0] trig);
        return p | (newr & ~trig) | (newr & ~oldr & trig);
    endfunction

    function automatic logic [N-1:0] f_after_clear(logic [N-1:0] p, logic [N-1:0] w,
                                                   logic [N-1:0] r, logic [N-1:0] trig);
        return (p & ~w) | (r & ~trig);
    endfunction

    task automatic set_req(logic [N-1:0] v);
        m_pend = f_after_req(m_pend, m_req, v, m_trig);
        m_req = v; req_i = v; settle();
    endtask

    task automatic check_all(string tag);
        logic [N-1:0] d;
        rd(2'd1, d); check({tag, " status"}, d, m_pend);
        rd(2'd0, d); check({tag, " enable"}, d, m_mask);
        rd(2'd2, d); check({tag, " trigger"}, d, m_trig);
        check({tag, " irq R5"}, {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, |(m_pend & m_mask)});
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [N-1:0] d, snap;
        void'($urandom(32'h1C0FFEE));
        m_pend = '0; m_mask = '0; m_trig = '0; m_req = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state
        check("R9 irq after reset", {{(N-1){1'b0}}, irq_o}, '0);
        check_all("R9");
        rd(2'd3, d); check("R8 unused address", d, '0);

        // R10 latency: level line 0 enabled
        wr(2'd0, 32'h1); m_mask = 32'h1;
        req_i = 32'h1;
        @(negedge clk); check("R10 edge k", {{(N-1){1'b0}}, irq_o}, '0);
        @(negedge clk); check("R10 edge k+1", {{(N-1){1'b0}}, irq_o}, '0);
        @(negedge clk); check("R10 edge k+2", {{(N-1){1'b0}}, irq_o}, 32'h1);
        m_req = 32'h1; m_pend = 32'h1;

        // R3 level re-set while asserted
        wr(2'd1, 32'h1); settle();
        rd(2'd1, d); check("R3 level re-pends", d, 32'h1);
        req_i = '0; m_req = '0; settle();
        wr(2'd1, 32'h1); m_pend = '0; settle();
        check_all("R3 cleared");

        // R4 edge lines 4 and 9
        wr(2'd2, 32'h0000_0210); m_trig = 32'h0000_0210;
        set_req(32'h0000_0010);
        set_req(32'h0);
        rd(2'd1, d); check("R4 edge held after fall", d, 32'h0000_0010);

        // R2 stale write-back keeps newer bit 9; R6 other bits untouched
        rd(2'd1, snap);
        set_req(32'h0000_0200);
        wr(2'd1, snap); m_pend = f_after_clear(m_pend, snap, m_req, m_trig);
        rd(2'd1, d); check("R2 stale write-back", d, 32'h0000_0200);

        // R1 write of zeros has no effect
        wr(2'd1, 32'h0); settle();
        rd(2'd1, d); check("R1 zero write", d, 32'h0000_0200);

        // R5 masked line still pends, no irq
        check("R5 masked no irq", {{(N-1){1'b0}}, irq_o}, '0);
        wr(2'd0, 32'h0000_0200); m_mask = 32'h0000_0200;
        check("R5 enabled irq", {{(N-1){1'b0}}, irq_o}, 32'h1);
        wr(2'd1, 32'h0000_0200); m_pend = '0;
        set_req(32'h0);

        // R7 event and clear in the same cycle on edge line 4
        req_i = 32'h0000_0010;
        @(negedge clk); @(negedge clk);
        wr(2'd1, 32'h0000_0010);
        settle();
        rd(2'd1, d); check("R7 set beats clear", d, 32'h0000_0010);
        m_req = 32'h0000_0010; m_pend = 32'h0000_0010;

        // Random mix, R1 R6 R8 across patterns
        for (int it = 0; it < 300; it++) begin
            int act;
            logic [N-1:0] v;
            act = $urandom_range(0, 3);
            v = $urandom();
            case (act)
                0: begin wr(2'd0, v); m_mask = v; end
                1: begin wr(2'd2, v); m_trig = v;
                         m_pend = m_pend | (m_req & ~v); settle(); end
                2: set_req(v);
                default: begin wr(2'd1, v);
                         m_pend = f_after_clear(m_pend, v, m_req, m_trig); settle(); end
            endcase
            if (it % 10 == 0) check_all("R1 R6 R8 random");
        end
        check_all("R8 final");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule